// File: doc/BRIEF.md
# Transmit Descriptor Queue Engine

This block runs the transmit side of a packet controller's descriptor handling. Transmit descriptors sit in one circular ring in memory, and completion records go to a second circular ring. The host programs a base, a length and a current pointer for each ring. It then adds work by writing a count of newly queued descriptors and turns the channel on. The engine fetches one descriptor at a time over a single-beat memory port. The frame length and an underrun marker carried in each descriptor stand in for the frame datapath. The engine then writes one status word for that frame and advances both ring pointers.

Two conditions stop the engine: a frame longer than the programmed maximum, and an underrun while halt-on-underrun is selected. When it stops, the engine drops its enable and raises a sticky flag. The host can restart from where processing left off by setting the enable again. It can also pulse a self-clearing channel reset, reprogram either ring, and then enable the channel so that processing starts from the new current pointers. An interrupt output combines the sticky flags that the host has unmasked.

Top module: `txq_engine`

## Requirements
- R1: After reset, the control register, the flag register, the interrupt mask and the pending count read 0, the maximum length reads 1518, all ring registers read 0 and `irq` is low.
- R2: Each fetched descriptor produces one status word at the status ring's current pointer. Bits [7:0] of the word hold the descriptor's position (current minus base). Bit 16 is set when neither error occurred, bit 17 marks a length error and bit 18 marks an underrun. A descriptor word carries the frame length in bits [15:0] and the underrun marker in bit 31. A memory request keeps its address and direction until it is granted.
- R3: Each ring pointer advances by one per descriptor fetched or status written, and moves from base+length-1 back to base.
- R4: Writing register 3 adds the written value to the pending count. Each fetch subtracts one. A fetch happens only while the enable bit is set and the count is non-zero.
- R5: A frame length greater than the maximum (register 10) sets flag bit 1 and clears the enable bit (control bit 0). A length equal to the maximum is accepted.
- R6: An underrun with control bit 2 set sets flag bit 2 and clears the enable bit. With control bit 2 clear, only status bit 18 records the underrun, no flag is raised and processing goes on.
- R7: Clearing control bit 0, or writing control bit 1 as 1, stops further fetches. Setting bit 0 again resumes at the unchanged descriptor pointer.
- R8: Writing control bit 3 as 1 starts a channel reset. Bit 3 reads 1 for 4 cycles and then 0, and the reset clears the enable bit and the pending count.
- R9: Writes to a ring's base, length or current register (descriptor ring at 4/5/6, status ring at 7/8/9) are ignored while the channel is enabled or busy. Once the channel is idle and disabled, new values are accepted, and the next enable starts from them.
- R10: Flag bit 0 (end of chain) is set when a fetch leaves the pending count at zero.
- R11: Flags stay set until the host writes 1 to the bit in register 1. `irq` is high when any flag is set whose bit is also set in the mask register 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = status write, 0 = descriptor read |
| mem_addr | output | 8 | Word address |
| mem_wdata | output | 32 | Status word to write |
| mem_gnt | input | 1 | Grant; completes the beat in the same cycle |
| mem_rdata | input | 32 | Read data, valid with the grant |
| irq | output | 1 | Interrupt, masked OR of the flags |

## Verification
A wrong pointer in either ring shows up at the ports as a status word landing at an unexpected address, or as a wrong position field. This appears within one frame, about six cycles after the enable. The bench follows both rings through several wraps of different lengths, so an off-by-one in the wrap point becomes visible within a few frames. A miscounted pending value shows up as the engine fetching while the count is zero, or as the end-of-chain flag not being set. A stuck enable or reset shows up in the next control read.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam logic [3:0] REG_CTRL   = 4'd0;
    localparam logic [3:0] REG_FLAGS  = 4'd1;
    localparam logic [3:0] REG_IRQEN  = 4'd2;
    localparam logic [3:0] REG_ENQ    = 4'd3;
    localparam logic [3:0] REG_MAXLEN = 4'd10;

    localparam int NUM_RINGS     = 2;
    localparam int RING_FIRST    = 4;
    localparam int RING_STRIDE   = 3;
    localparam int RING_OFS_BASE = 0;
    localparam int RING_OFS_LEN  = 1;
    localparam int RING_OFS_CUR  = 2;

    localparam int CTRL_EN  = 0;
    localparam int CTRL_DIS = 1;
    localparam int CTRL_HOU = 2;
    localparam int CTRL_RST = 3;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_FETCH,
        ENG_STATUS
    } eng_state_t;

    typedef struct packed {
        logic        urun;
        logic [14:0] rsvd;
        logic [15:0] len;
    } desc_t;

    typedef struct packed {
        logic [12:0] rsvd_hi;
        logic        urun;
        logic        len_err;
        logic        ok;
        logic [7:0]  rsvd_lo;
        logic [7:0]  idx;
    } status_t;

    typedef struct packed {
        logic urun_halt;
        logic len_err;
        logic eoc;
    } flags_t;

    function automatic status_t make_status(input logic [7:0] idx,
                                            input desc_t d,
                                            input logic [15:0] maxlen);
        status_t s;
        s         = '0;
        s.idx     = idx;
        s.urun    = d.urun;
        s.len_err = (d.len > maxlen);
        s.ok      = !(d.urun || (d.len > maxlen));
        return s;
    endfunction

    function automatic logic [3:0] ring_reg(input int ring, input int ofs);
        return 4'(RING_FIRST + RING_STRIDE * ring + ofs);
    endfunction

endpackage

// File: rtl/txq_ring.sv
module txq_ring #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_base,
    input  logic          wr_len,
    input  logic          wr_cur,
    input  logic [AW-1:0] wdata,
    input  logic          step,
    output logic [AW-1:0] base,
    output logic [AW-1:0] len,
    output logic [AW-1:0] cur
);
    localparam int EW = AW + 1;

    logic [EW-1:0] end_a;
    logic [EW-1:0] inc_a;

    assign end_a = {1'b0, base} + {1'b0, len};
    assign inc_a = {1'b0, cur} + EW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
            len  <= '0;
            cur  <= '0;
        end else begin
            if (wr_base) base <= wdata;
            if (wr_len)  len  <= wdata;
            if (wr_cur) begin
                cur <= wdata;
            end else if (step) begin
                cur <= (inc_a >= end_a) ? base : inc_a[AW-1:0];
            end
        end
    end

    // R3: a pointer that starts inside its ring stays inside it
    assert_in_ring_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_base && !wr_len && !wr_cur && len != '0 &&
         cur >= base && inc_a <= end_a)
        |=> (cur >= base) && ({1'b0, cur} < end_a));

endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int RST_CYCLES = 4,
    parameter int MAXLEN_RST = 1518
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic             wr_flags,
    input  logic             wr_irqen,
    input  logic             wr_enq,
    input  logic             wr_maxlen,
    input  logic [31:0]      wdata,
    input  logic             fetch,
    input  logic             halt,
    input  flags_t           set_flags,
    output logic             tx_en,
    output logic             hou,
    output logic             chan_rst,
    output logic [CNT_W-1:0] enq_cnt,
    output logic [15:0]      maxlen,
    output flags_t           flags,
    output flags_t           irq_en,
    output logic             irq
);
    localparam int RCW = $clog2(RST_CYCLES + 1);

    logic [RCW-1:0]   rst_cnt;
    logic [CNT_W-1:0] enq_add;
    logic [CNT_W-1:0] enq_nxt;
    logic             eoc_hit;
    flags_t           set_all;
    flags_t           clr;
    logic             unused_hi;

    assign unused_hi = ^wdata[31:16];
    assign chan_rst  = (rst_cnt != '0);

    always_comb begin
        enq_add     = wr_enq ? wdata[CNT_W-1:0] : '0;
        enq_nxt     = enq_cnt + enq_add - CNT_W'(fetch);
        eoc_hit     = fetch && (enq_nxt == '0);
        set_all     = set_flags;
        set_all.eoc = set_flags.eoc | eoc_hit;
        clr         = wr_flags ? flags_t'(wdata[2:0]) : flags_t'('0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en   <= 1'b0;
            hou     <= 1'b0;
            rst_cnt <= '0;
            enq_cnt <= '0;
            maxlen  <= 16'(MAXLEN_RST);
            flags   <= '0;
            irq_en  <= '0;
        end else begin
            if (rst_cnt != '0) rst_cnt <= rst_cnt - RCW'(1);
            if (wr_ctrl) begin
                hou   <= wdata[CTRL_HOU];
                tx_en <= wdata[CTRL_EN] & ~wdata[CTRL_DIS];
                if (wdata[CTRL_RST]) begin
                    rst_cnt <= RCW'(RST_CYCLES);
                    tx_en   <= 1'b0;
                end
            end
            if (halt || chan_rst) tx_en <= 1'b0;
            enq_cnt <= chan_rst ? '0 : enq_nxt;
            flags   <= (flags & ~clr) | set_all;
            if (wr_irqen)  irq_en <= flags_t'(wdata[2:0]);
            if (wr_maxlen) maxlen <= wdata[15:0];
        end
    end

    assign irq = |(flags & irq_en);

    // R4: a fetch without a concurrent host add lowers the count by one
    assert_enq_dec_R4: assert property (@(posedge clk) disable iff (rst)
        (fetch && !wr_enq && !chan_rst) |=> enq_cnt == $past(enq_cnt) - CNT_W'(1));

    // R11: a write-one clears the length-error flag unless it is set again
    assert_w1c_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_flags && wdata[1] && !set_flags.len_err) |=> !flags.len_err);

    // R8: the channel reset counts down by one per cycle
    assert_rst_countdown_R8: assert property (@(posedge clk) disable iff (rst)
        (chan_rst && !(wr_ctrl && wdata[CTRL_RST])) |=> rst_cnt == $past(rst_cnt) - RCW'(1));

endmodule

// File: rtl/txq_fsm.sv
module txq_fsm
    import txq_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chan_rst,
    input  logic          tx_en,
    input  logic          enq_nz,
    input  logic          hou,
    input  logic [15:0]   maxlen,
    input  logic [AW-1:0] dbase,
    input  logic [AW-1:0] dcur,
    input  logic [AW-1:0] scur,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_gnt,
    input  logic [31:0]   mem_rdata,
    output logic          fetch,
    output logic          sstep,
    output logic          halt,
    output flags_t        set_flags,
    output logic          busy
);
    eng_state_t state_q;
    status_t    stat_q;
    logic       go;
    logic       unused_rd;

    assign unused_rd = ^mem_rdata[30:16];
    assign busy      = (state_q != ENG_IDLE);
    assign go        = mem_req && mem_gnt;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        fetch     = 1'b0;
        sstep     = 1'b0;
        halt      = 1'b0;
        set_flags = '0;
        unique case (state_q)
            ENG_FETCH: begin
                mem_req  = !chan_rst;
                mem_addr = dcur;
                fetch    = go;
            end
            ENG_STATUS: begin
                mem_req   = !chan_rst;
                mem_we    = 1'b1;
                mem_addr  = scur;
                mem_wdata = stat_q;
                sstep     = go;
                halt      = go && (stat_q.len_err || (stat_q.urun && hou));
                set_flags.len_err   = go && stat_q.len_err;
                set_flags.urun_halt = go && stat_q.urun && hou;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            stat_q  <= '0;
        end else if (chan_rst) begin
            state_q <= ENG_IDLE;
        end else begin
            unique case (state_q)
                ENG_IDLE: if (tx_en && enq_nz) state_q <= ENG_FETCH;
                ENG_FETCH: if (go) begin
                    stat_q  <= make_status(8'(dcur - dbase), desc_t'(mem_rdata), maxlen);
                    state_q <= ENG_STATUS;
                end
                ENG_STATUS: if (go) state_q <= ENG_IDLE;
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    // R2: an ungranted request holds its address and direction
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst || chan_rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4: descriptor reads only happen while work is pending
    assert_fetch_pending_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> enq_nz);

endmodule

// File: rtl/txq_engine.sv
module txq_engine
    import txq_pkg::*;
#(
    parameter int AW         = 8,
    parameter int CNT_W      = 16,
    parameter int RST_CYCLES = 4,
    parameter int MAXLEN_RST = 1518
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_gnt,
    input  logic [31:0]   mem_rdata,
    output logic          irq
);
    localparam int DESC_RING = 0;
    localparam int STAT_RING = 1;

    logic             tx_en, hou, chan_rst, busy, lock;
    logic             fetch, sstep, halt;
    logic [CNT_W-1:0] enq_cnt;
    logic [15:0]      maxlen;
    flags_t           flags, irq_en, set_flags;
    logic [AW-1:0]    rb [NUM_RINGS];
    logic [AW-1:0]    rl [NUM_RINGS];
    logic [AW-1:0]    rc [NUM_RINGS];
    logic [NUM_RINGS-1:0] rstep;

    assign lock  = tx_en | busy;
    assign rstep = {sstep, fetch};

    txq_ctrl #(
        .CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES), .MAXLEN_RST(MAXLEN_RST)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .wr_ctrl  (reg_wr && reg_addr == REG_CTRL),
        .wr_flags (reg_wr && reg_addr == REG_FLAGS),
        .wr_irqen (reg_wr && reg_addr == REG_IRQEN),
        .wr_enq   (reg_wr && reg_addr == REG_ENQ),
        .wr_maxlen(reg_wr && reg_addr == REG_MAXLEN),
        .wdata(reg_wdata), .fetch(fetch), .halt(halt), .set_flags(set_flags),
        .tx_en(tx_en), .hou(hou), .chan_rst(chan_rst), .enq_cnt(enq_cnt),
        .maxlen(maxlen), .flags(flags), .irq_en(irq_en), .irq(irq)
    );

    for (genvar gi = 0; gi < NUM_RINGS; gi++) begin : g_ring
        localparam logic [3:0] A_BASE = ring_reg(gi, RING_OFS_BASE);
        localparam logic [3:0] A_LEN  = ring_reg(gi, RING_OFS_LEN);
        localparam logic [3:0] A_CUR  = ring_reg(gi, RING_OFS_CUR);
        txq_ring #(.AW(AW)) u_ring (
            .clk(clk), .rst(rst),
            .wr_base(reg_wr && !lock && reg_addr == A_BASE),
            .wr_len (reg_wr && !lock && reg_addr == A_LEN),
            .wr_cur (reg_wr && !lock && reg_addr == A_CUR),
            .wdata(reg_wdata[AW-1:0]), .step(rstep[gi]),
            .base(rb[gi]), .len(rl[gi]), .cur(rc[gi])
        );
    end

    txq_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst(rst), .chan_rst(chan_rst), .tx_en(tx_en),
        .enq_nz(enq_cnt != '0), .hou(hou), .maxlen(maxlen),
        .dbase(rb[DESC_RING]), .dcur(rc[DESC_RING]), .scur(rc[STAT_RING]),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .fetch(fetch), .sstep(sstep), .halt(halt), .set_flags(set_flags),
        .busy(busy)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_CTRL:   reg_rdata = 32'({chan_rst, hou, 1'b0, tx_en});
            REG_FLAGS:  reg_rdata = 32'(flags);
            REG_IRQEN:  reg_rdata = 32'(irq_en);
            REG_ENQ:    reg_rdata = 32'(enq_cnt);
            REG_MAXLEN: reg_rdata = 32'(maxlen);
            default: begin
                for (int r = 0; r < NUM_RINGS; r++) begin
                    if (reg_addr == ring_reg(r, RING_OFS_BASE)) reg_rdata = 32'(rb[r]);
                    if (reg_addr == ring_reg(r, RING_OFS_LEN))  reg_rdata = 32'(rl[r]);
                    if (reg_addr == ring_reg(r, RING_OFS_CUR))  reg_rdata = 32'(rc[r]);
                end
            end
        endcase
    end

    // R5/R6: a halting status write drops the enable on the next cycle
    assert_halt_stops_R5: assert property (@(posedge clk) disable iff (rst)
        halt |=> !tx_en);

    // R9: ring base writes are ignored while the channel is enabled
    assert_base_locked_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_en && reg_wr && reg_addr == ring_reg(DESC_RING, RING_OFS_BASE))
        |=> $stable(rb[DESC_RING]));

endmodule

// File: tb/sim_txq_engine.sv
module sim_txq_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_gnt, irq;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    logic [31:0] mem [256];
    logic        gnt_ok = 1'b0;
    logic        bd_we = 1'b0;
    logic [7:0]  bd_addr = '0;
    logic [31:0] bd_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign mem_gnt   = mem_req && gnt_ok;
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        gnt_ok <= ~gnt_ok;
        if (bd_we) mem[bd_addr] <= bd_data;
        else if (mem_req && mem_we && mem_gnt) mem[mem_addr] <= mem_wdata;
    end

    txq_engine u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq(irq)
    );

    // [33] expected halt, [32] halt-on-underrun, [31:0] descriptor word
    localparam logic [33:0] VEC [8] = '{
        {1'b0, 1'b0, 32'h0000_0040},
        {1'b0, 1'b0, 32'h0000_0064},
        {1'b1, 1'b0, 32'h0000_0065},
        {1'b0, 1'b0, 32'h8000_000A},
        {1'b1, 1'b1, 32'h8000_000A},
        {1'b0, 1'b1, 32'h0000_0032},
        {1'b1, 1'b1, 32'h0000_00C8},
        {1'b0, 1'b0, 32'h0000_0001}
    };
    localparam int MAXL = 100;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic bd(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bd_we = 1'b1; bd_addr = a; bd_data = d;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    function automatic logic [31:0] exp_status(input logic [7:0] idx, input logic [31:0] d);
        logic le, ur;
        le = (d[15:0] > 16'(MAXL));
        ur = d[31];
        return {13'b0, ur, le, ~(le | ur), 8'b0, idx};
    endfunction

    function automatic logic [7:0] adv(input logic [7:0] p, input logic [7:0] b, input logic [7:0] l);
        return (p + 8'd1 == b + l) ? b : p + 8'd1;
    endfunction

    initial begin
        logic [31:0] v;
        logic [7:0]  dexp, sexp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        rd(REG_CTRL_A, v);  chk("R1 ctrl", v, 0);
        rd(4'd1, v);        chk("R1 flags", v, 0);
        rd(4'd3, v);        chk("R1 enq", v, 0);
        rd(4'd10, v);       chk("R1 maxlen", v, 1518);
        rd(4'd6, v);        chk("R1 dcur", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        wr(4'd4, 16); wr(4'd5, 3); wr(4'd6, 16);
        wr(4'd7, 64); wr(4'd8, 5); wr(4'd9, 64);
        wr(4'd10, MAXL);
        dexp = 8'd16; sexp = 8'd64;

        for (int i = 0; i < 8; i++) begin
            logic [31:0] d, st;
            logic hv, le, ur, hexp;
            d  = VEC[i][31:0];
            hv = VEC[i][32];
            le = (d[15:0] > 16'(MAXL));
            ur = d[31];
            hexp = le | (ur & hv);
            bd(dexp, d);
            wr(4'd0, {29'b0, hv, 2'b01});
            wr(4'd3, 1);
            repeat (12) @(negedge clk);
            st = exp_status(dexp - 8'd16, d);
            chk("R2 status word", mem[sexp], st);
            dexp = adv(dexp, 8'd16, 8'd3);
            sexp = adv(sexp, 8'd64, 8'd5);
            rd(4'd6, v); chk("R3 desc ptr", v, {24'b0, dexp});
            rd(4'd9, v); chk("R3 stat ptr", v, {24'b0, sexp});
            rd(4'd1, v); chk("R5 R6 R10 flags", v, {29'b0, ur & hv, le, 1'b1});
            rd(4'd0, v); chk("R5 R6 enable", {31'b0, v[0]}, {31'b0, ~hexp});
            chk("R5 R6 table halt", {31'b0, hexp}, {31'b0, VEC[i][33]});
            rd(4'd3, v); chk("R4 enq drained", v, 0);
            wr(4'd1, 7);
            wr(4'd0, 0);
        end

        // R7: disabled channel does not fetch; enable resumes at same point
        bd(dexp, 32'h0000_0005);
        bd(adv(dexp, 8'd16, 8'd3), 32'h0000_0006);
        wr(4'd3, 2);
        repeat (10) @(negedge clk);
        rd(4'd3, v); chk("R4 R7 enq held", v, 2);
        rd(4'd6, v); chk("R7 ptr held", v, {24'b0, dexp});
        wr(4'd2, 1);
        chk("R11 irq clear before", {31'b0, irq}, 0);
        wr(4'd0, 1);
        repeat (20) @(negedge clk);
        rd(4'd3, v); chk("R4 enq zero", v, 0);
        dexp = adv(adv(dexp, 8'd16, 8'd3), 8'd16, 8'd3);
        rd(4'd6, v); chk("R7 resumed", v, {24'b0, dexp});
        rd(4'd1, v); chk("R10 eoc", v, 1);
        chk("R11 irq high", {31'b0, irq}, 1);
        wr(4'd1, 1);
        rd(4'd1, v); chk("R11 w1c", v, 0);
        chk("R11 irq low", {31'b0, irq}, 0);

        // R9: ring writes ignored while enabled
        wr(4'd6, 20);
        rd(4'd6, v); chk("R9 cur locked", v, {24'b0, dexp});
        wr(4'd4, 99);
        rd(4'd4, v); chk("R9 base locked", v, 16);

        // R7: disable bit wins over enable bit
        wr(4'd0, 3);
        rd(4'd0, v); chk("R7 dis bit", {31'b0, v[0]}, 0);

        // R8: channel reset
        wr(4'd3, 5);
        wr(4'd0, 8);
        rd(4'd0, v); chk("R8 busy bit", {31'b0, v[3]}, 1);
        repeat (6) @(negedge clk);
        rd(4'd0, v); chk("R8 self clear", v, 0);
        rd(4'd3, v); chk("R8 enq cleared", v, 0);

        // R9: restart from new point
        wr(4'd4, 32); wr(4'd5, 2); wr(4'd6, 33);
        wr(4'd7, 80); wr(4'd8, 2); wr(4'd9, 81);
        bd(8'd33, 32'h0000_0005);
        wr(4'd3, 1);
        wr(4'd0, 1);
        repeat (12) @(negedge clk);
        chk("R9 new point status", mem[81], 32'h0001_0001);
        rd(4'd6, v); chk("R3 R9 desc wrap", v, 32);
        rd(4'd9, v); chk("R3 R9 stat wrap", v, 80);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        done = 1;
        $finish;
    end

    localparam logic [3:0] REG_CTRL_A = 4'd0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule